// File: doc/BRIEF.md
# I2C Multi-Master Mode and Status Tracker

This block keeps the mode and status state of a multi-master I2C controller. It watches the synchronized SCL and SDA samples and finds START and STOP conditions. From these it keeps a bus-busy flag. It also holds the two mode bits, master/slave and transmit/receive. The master bit drops by itself when arbitration was lost in the byte just finished, when a STOP is seen, or when a START request arrives while the bus is already busy. In that last case the START is refused, so no grant pulse goes to the shifter or the clock generator.

The block shows its state as one 8-bit status byte. The byte carries read-only flags and an active-low interrupt-pending bit. An interrupt line stays high while a request is pending. A CPU write port can change only the mode bits and the pending bit, and the pending bit can only be cleared through it. Byte shifting, address comparison and SCL generation belong to neighbouring blocks. Those blocks drive the event pulses that this block receives.

Top module: `mm_i2c_state_track`

## Requirements
- R1: After reset the status byte reads 0001000 in bits 7..1 and the LRB_INIT value in bit 0. `irq_o` and `start_go_o` are low. The bit positions are: 7 master (MST), 6 transmit (TRX), 5 bus busy (BB), 4 pending-not (PIN), 3 arbitration lost (AL), 2 addressed (AAS), 1 general call (AD0), 0 last received bit (LRB).
- R2: A falling SDA while SCL is high, in both the previous and the current sample, is a START and sets BB on the next clock. A rising SDA under the same condition is a STOP and clears BB. SDA changes while SCL is low change nothing.
- R3: A CPU write loads MST from data bit 7 and TRX from data bit 6, unless an automatic clear wins for MST. {MST,TRX} = 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit.
- R4: A detected STOP clears MST on the next clock and overrides a CPU write in the same cycle.
- R5: A byte-complete pulse clears MST when AL is set, or when an arbitration-lost pulse comes in the same cycle.
- R6: A START request while BB is set clears MST and gives no grant. A START request while BB is clear raises `start_go_o` for exactly the next cycle.
- R7: A byte-complete pulse drives PIN to 0, and `irq_o` is high while PIN is 0. A CPU write with data bit 4 at 1 sets PIN back to 1. A byte-complete pulse in the same cycle wins.
- R8: A CPU write with data bit 4 at 0 leaves PIN unchanged.
- R9: CPU writes have no effect on bits 5, 3, 2, 1 and 0.
- R10: Arbitration-lost, address-match and general-call pulses set AL, AAS and AD0 respectively. A START or a STOP clears all three, and a set pulse in the same cycle wins.
- R11: On each byte-complete pulse, LRB takes the value of `last_bit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| wr_en_i | input | 1 | CPU write strobe for the status byte |
| wr_data_i | input | 8 | CPU write data |
| start_req_i | input | 1 | Pulse: software asks for a START |
| arb_lost_i | input | 1 | Pulse: arbitration lost |
| byte_done_i | input | 1 | Pulse: byte transfer and acknowledge complete |
| last_bit_i | input | 1 | SDA value at the ninth clock |
| addr_match_i | input | 1 | Pulse: own slave address matched |
| gen_call_i | input | 1 | Pulse: general call address received |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request, high while PIN is 0 |
| start_go_o | output | 1 | One-cycle grant of a requested START |

## Verification
With the default zero-length line filter, every result of this block is due exactly one clock after the edge that samples its stimulus. This covers BB after a START or STOP, the mode bits after a write or an automatic clear, the flags and LRB after their pulses, and the `start_go_o` grant. `irq_o` follows PIN with no further delay. The bench changes its inputs just after a falling edge, and the reference model advances on the next rising edge. Every output is compared at the falling edge after that, which gives exactly the one-cycle latency the requirements call for. In cycles where two events meet, the model applies the priorities from the requirements, so the same-cycle collisions are checked against those priorities.

// File: rtl/mmst_pkg.sv
package mmst_pkg;
   localparam int unsigned ST_W  = 8;
   localparam int unsigned B_MST = 7;
   localparam int unsigned B_TRX = 6;
   localparam int unsigned B_BB  = 5;
   localparam int unsigned B_PIN = 4;
   localparam int unsigned B_AL  = 3;
   localparam int unsigned B_AAS = 2;
   localparam int unsigned B_AD0 = 1;
   localparam int unsigned B_LRB = 0;

   typedef enum logic [1:0] {
      MODE_SLV_RX = 2'b00,
      MODE_SLV_TX = 2'b01,
      MODE_MST_RX = 2'b10,
      MODE_MST_TX = 2'b11
   } mode_e;

   typedef struct packed {
      logic start;
      logic stop;
   } buscond_t;
endpackage

// File: rtl/mmst_line_watch.sv
module mmst_line_watch
   import mmst_pkg::*;
#(
   parameter int unsigned FILTER_LEN = 0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output buscond_t cond_o,
   output logic     bb_o
);
   logic scl_f, sda_f;
   logic scl_prev, sda_prev;
   logic bb_q;

   // Optional glitch filter: a line value is accepted only once every tap agrees
   generate
      if (FILTER_LEN == 0) begin : g_direct
         assign scl_f = scl_i;
         assign sda_f = sda_i;
      end else begin : g_filter
         localparam int unsigned HW = FILTER_LEN;
         logic [HW-1:0] scl_h, sda_h;
         logic          scl_s, sda_s;
         if (HW == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_h <= 1'b1;
                  sda_h <= 1'b1;
               end else begin
                  scl_h <= scl_i;
                  sda_h <= sda_i;
               end
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_h <= '1;
                  sda_h <= '1;
               end else begin
                  scl_h <= {scl_h[HW-2:0], scl_i};
                  sda_h <= {sda_h[HW-2:0], sda_i};
               end
            end
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_s <= 1'b1;
               sda_s <= 1'b1;
            end else begin
               if (&scl_h)       scl_s <= 1'b1;
               else if (~|scl_h) scl_s <= 1'b0;
               if (&sda_h)       sda_s <= 1'b1;
               else if (~|sda_h) sda_s <= 1'b0;
            end
         end
         assign scl_f = scl_s;
         assign sda_f = sda_s;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_f;
         sda_prev <= sda_f;
      end
   end

   assign cond_o.start = scl_prev & scl_f &  sda_prev & ~sda_f;
   assign cond_o.stop  = scl_prev & scl_f & ~sda_prev &  sda_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            bb_q <= 1'b0;
      else if (cond_o.start) bb_q <= 1'b1;
      else if (cond_o.stop)  bb_q <= 1'b0;
   end
   assign bb_o = bb_q;

   assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cond_o.start |=> bb_o);
   assert_stop_frees_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cond_o.stop |=> !bb_o);
   assert_busy_needs_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cond_o.start && !cond_o.stop) |=> $stable(bb_o));
endmodule

// File: rtl/mmst_mode_ctl.sv
module mmst_mode_ctl
   import mmst_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  buscond_t cond_i,
   input  logic     bb_i,
   input  logic     al_i,
   input  logic     wr_en_i,
   input  logic     wr_mst_i,
   input  logic     wr_trx_i,
   input  logic     start_req_i,
   input  logic     arb_lost_i,
   input  logic     byte_done_i,
   output logic     mst_o,
   output logic     trx_o,
   output logic     start_go_o
);
   logic mst_q, trx_q, go_q;
   logic clr_stop, clr_arb, clr_dup, mst_clr;

   assign clr_stop = cond_i.stop;
   assign clr_arb  = byte_done_i & (al_i | arb_lost_i);
   assign clr_dup  = start_req_i & bb_i;
   assign mst_clr  = clr_stop | clr_arb | clr_dup;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_q <= 1'b0;
         trx_q <= 1'b0;
         go_q  <= 1'b0;
      end else begin
         if (mst_clr)      mst_q <= 1'b0;
         else if (wr_en_i) mst_q <= wr_mst_i;
         if (wr_en_i)      trx_q <= wr_trx_i;
         go_q <= start_req_i & ~bb_i;
      end
   end

   assign mst_o      = mst_q;
   assign trx_o      = trx_q;
   assign start_go_o = go_q;

   assert_stop_drops_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cond_i.stop |=> !mst_o);
   assert_lost_byte_drops_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done_i && (al_i || arb_lost_i)) |=> !mst_o);
   assert_dup_start_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req_i && bb_i) |=> (!mst_o && !start_go_o));
   assert_free_start_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req_i && !bb_i) |=> start_go_o);
   assert_grant_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !start_req_i |=> !start_go_o);
endmodule

// File: rtl/mmst_flag_bank.sv
module mmst_flag_bank
   import mmst_pkg::*;
#(
   parameter logic LRB_INIT = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  buscond_t cond_i,
   input  logic     arb_lost_i,
   input  logic     addr_match_i,
   input  logic     gen_call_i,
   input  logic     byte_done_i,
   input  logic     last_bit_i,
   input  logic     wr_en_i,
   input  logic     wr_pin_i,
   output logic     al_o,
   output logic     aas_o,
   output logic     ad0_o,
   output logic     lrb_o,
   output logic     pin_o
);
   localparam int unsigned NSTICKY = 3;

   logic [NSTICKY-1:0] set_v, flag_q;
   logic               cond_clr;
   logic               lrb_q, pin_q;

   assign set_v    = {gen_call_i, addr_match_i, arb_lost_i};
   assign cond_clr = cond_i.start | cond_i.stop;

   // Sticky event flags: a set pulse wins over the START/STOP clear
   generate
      for (genvar k = 0; k < NSTICKY; k++) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_q[k] <= 1'b0;
            else if (set_v[k])  flag_q[k] <= 1'b1;
            else if (cond_clr)  flag_q[k] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           lrb_q <= LRB_INIT;
      else if (byte_done_i) lrb_q <= last_bit_i;
   end

   // Active-low pending bit: a new request wins over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pin_q <= 1'b1;
      else if (byte_done_i)           pin_q <= 1'b0;
      else if (wr_en_i && wr_pin_i)   pin_q <= 1'b1;
   end

   assign al_o  = flag_q[0];
   assign aas_o = flag_q[1];
   assign ad0_o = flag_q[2];
   assign lrb_o = lrb_q;
   assign pin_o = pin_q;

   assert_byte_raises_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done_i |=> !pin_o);
   assert_pin_one_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_pin_i && !byte_done_i) |=> pin_o);
   assert_pin_zero_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_pin_i && !byte_done_i) |=> $stable(pin_o));
   assert_addr_sets_aas_R10: assert property (@(posedge clk) disable iff (!rst_n)
      addr_match_i |=> aas_o);
   assert_cond_clears_al_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_clr && !arb_lost_i) |=> !al_o);
   assert_lrb_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done_i |=> (lrb_o == $past(last_bit_i)));
endmodule

// File: rtl/mm_i2c_state_track.sv
module mm_i2c_state_track
   import mmst_pkg::*;
#(
   parameter int unsigned FILTER_LEN = 0,
   parameter logic        LRB_INIT   = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_i,
   input  logic            sda_i,
   input  logic            wr_en_i,
   input  logic [ST_W-1:0] wr_data_i,
   input  logic            start_req_i,
   input  logic            arb_lost_i,
   input  logic            byte_done_i,
   input  logic            last_bit_i,
   input  logic            addr_match_i,
   input  logic            gen_call_i,
   output logic [ST_W-1:0] status_o,
   output logic            irq_o,
   output logic            start_go_o
);
   generate
      if (FILTER_LEN > 16) begin : g_bad_filter
         $error("FILTER_LEN must not exceed 16");
      end
      if (ST_W != 8) begin : g_bad_width
         $error("status byte must be 8 bits wide");
      end
   endgenerate

   buscond_t cond;
   logic     bb, mst, trx, al, aas, ad0, lrb, pin;
   logic     ro_sink;

   mmst_line_watch #(.FILTER_LEN(FILTER_LEN)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_i),
      .sda_i  (sda_i),
      .cond_o (cond),
      .bb_o   (bb)
   );

   mmst_mode_ctl u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .cond_i      (cond),
      .bb_i        (bb),
      .al_i        (al),
      .wr_en_i     (wr_en_i),
      .wr_mst_i    (wr_data_i[B_MST]),
      .wr_trx_i    (wr_data_i[B_TRX]),
      .start_req_i (start_req_i),
      .arb_lost_i  (arb_lost_i),
      .byte_done_i (byte_done_i),
      .mst_o       (mst),
      .trx_o       (trx),
      .start_go_o  (start_go_o)
   );

   mmst_flag_bank #(.LRB_INIT(LRB_INIT)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .cond_i       (cond),
      .arb_lost_i   (arb_lost_i),
      .addr_match_i (addr_match_i),
      .gen_call_i   (gen_call_i),
      .byte_done_i  (byte_done_i),
      .last_bit_i   (last_bit_i),
      .wr_en_i      (wr_en_i),
      .wr_pin_i     (wr_data_i[B_PIN]),
      .al_o         (al),
      .aas_o        (aas),
      .ad0_o        (ad0),
      .lrb_o        (lrb),
      .pin_o        (pin)
   );

   always_comb begin
      status_o        = '0;
      status_o[B_MST] = mst;
      status_o[B_TRX] = trx;
      status_o[B_BB]  = bb;
      status_o[B_PIN] = pin;
      status_o[B_AL]  = al;
      status_o[B_AAS] = aas;
      status_o[B_AD0] = ad0;
      status_o[B_LRB] = lrb;
   end

   assign irq_o = ~pin;

   // Write data in read-only positions is deliberately discarded
   assign ro_sink = ^{wr_data_i[B_BB], wr_data_i[B_AL], wr_data_i[B_AAS],
                      wr_data_i[B_AD0], wr_data_i[B_LRB]};

   assert_ro_bits_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !cond.start && !cond.stop && !arb_lost_i && !addr_match_i &&
       !gen_call_i && !byte_done_i)
      |=> ($stable(status_o[B_BB]) && $stable(status_o[B_AL]) && $stable(status_o[B_AAS]) &&
           $stable(status_o[B_AD0]) && $stable(status_o[B_LRB])));
   assert_mode_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !cond.stop && !(start_req_i && bb) && !(byte_done_i && (al || arb_lost_i)))
      |=> (status_o[B_MST:B_TRX] == $past({wr_data_i[B_MST], wr_data_i[B_TRX]})));
   assert_irq_tracks_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done_i |=> irq_o);
   assert_ro_sink_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |-> !$isunknown(ro_sink));
endmodule

// File: tb/test_mm_i2c_state_track.sv
`timescale 1ns/1ps
module test_mm_i2c_state_track;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1, sda = 1'b1, wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       start_req = 1'b0, arb_lost = 1'b0, byte_done = 1'b0;
   logic       last_bit = 1'b0, addr_match = 1'b0, gen_call = 1'b0;
   logic [7:0] status;
   logic       irq, start_go;

   int checks = 0;
   int errors = 0;

   // reference model state
   bit m_mst, m_trx, m_bb, m_pin, m_al, m_aas, m_ad0, m_lrb, m_go;
   bit m_pscl, m_psda;

   always #4 clk = ~clk;

   mm_i2c_state_track i_mm_i2c_state_track (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .wr_en_i(wr_en), .wr_data_i(wr_data), .start_req_i(start_req),
      .arb_lost_i(arb_lost), .byte_done_i(byte_done), .last_bit_i(last_bit),
      .addr_match_i(addr_match), .gen_call_i(gen_call),
      .status_o(status), .irq_o(irq), .start_go_o(start_go)
   );

   task automatic model_reset();
      m_mst = 0; m_trx = 0; m_bb = 0; m_pin = 1; m_al = 0; m_aas = 0;
      m_ad0 = 0; m_lrb = 0; m_go = 0; m_pscl = 1; m_psda = 1;
   endtask

   task automatic model_step();
      bit st, sp, clr_m;
      st = m_pscl && scl && m_psda && !sda;
      sp = m_pscl && scl && !m_psda && sda;
      clr_m = sp || (byte_done && (m_al || arb_lost)) || (start_req && m_bb);
      m_go = start_req && !m_bb;
      if (clr_m) m_mst = 0;
      else if (wr_en) m_mst = wr_data[7];
      if (wr_en) m_trx = wr_data[6];
      if (st) m_bb = 1;
      else if (sp) m_bb = 0;
      if (arb_lost) m_al = 1;   else if (st || sp) m_al = 0;
      if (addr_match) m_aas = 1; else if (st || sp) m_aas = 0;
      if (gen_call) m_ad0 = 1;  else if (st || sp) m_ad0 = 0;
      if (byte_done) m_lrb = last_bit;
      if (byte_done) m_pin = 0;
      else if (wr_en && wr_data[4]) m_pin = 1;
      m_pscl = scl;
      m_psda = sda;
   endtask

   task automatic compare(input string tag);
      logic [7:0] exp_st;
      exp_st = {m_mst, m_trx, m_bb, m_pin, m_al, m_aas, m_ad0, m_lrb};
      checks++;
      if (status !== exp_st) begin
         errors++;
         $display("FAIL %s status act=%b exp=%b", tag, status, exp_st);
      end
      checks++;
      if (irq !== !m_pin) begin
         errors++;
         $display("FAIL %s irq act=%b exp=%b", tag, irq, !m_pin);
      end
      checks++;
      if (start_go !== m_go) begin
         errors++;
         $display("FAIL %s start_go act=%b exp=%b", tag, start_go, m_go);
      end
   endtask

   task automatic cyc(input logic c_scl, input logic c_sda, input logic c_wr,
                      input logic [7:0] c_wd, input logic c_req, input logic c_arb,
                      input logic c_bd, input logic c_last, input logic c_am,
                      input logic c_gc, input string tag);
      scl = c_scl; sda = c_sda; wr_en = c_wr; wr_data = c_wd;
      start_req = c_req; arb_lost = c_arb; byte_done = c_bd;
      last_bit = c_last; addr_match = c_am; gen_call = c_gc;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input string tag);
      cyc(scl, sda, 0, 8'h00, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic wr(input logic [7:0] d, input string tag);
      cyc(scl, sda, 1, d, 0, 0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1 reset state");
      idle("R1 idle after reset");

      wr(8'hC0, "R3 master transmit 11");
      wr(8'h80, "R3 master receive 10");
      wr(8'h40, "R3 slave transmit 01");
      wr(8'h00, "R3 slave receive 00");
      wr(8'hC0, "R3 master transmit again");

      cyc(0, 1, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R2 scl low");
      cyc(0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R2 sda fall scl low");
      cyc(0, 1, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R2 sda rise scl low");
      cyc(1, 1, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R2 scl rise");
      cyc(1, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R2 start sets busy");
      cyc(0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R2 scl low busy");

      cyc(0, 0, 0, 8'h00, 0, 0, 0, 0, 1, 0, "R10 address match");
      cyc(0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 1, "R10 general call");
      cyc(0, 0, 0, 8'h00, 0, 0, 1, 1, 0, 0, "R7 R11 byte done last 1");
      idle("R7 irq held");
      wr(8'hC0, "R8 pin write zero ignored");
      wr(8'hEF, "R9 read only bits ignored");
      wr(8'hD0, "R7 pin clear by write one");
      cyc(0, 0, 1, 8'hD0, 0, 0, 1, 0, 0, 0, "R7 R11 byte done beats clear");
      wr(8'hD0, "R7 clear again");

      cyc(0, 0, 0, 8'h00, 1, 0, 0, 0, 0, 0, "R6 start refused while busy");
      wr(8'hC0, "R3 master again");
      cyc(0, 0, 1, 8'hC0, 1, 0, 0, 0, 0, 0, "R6 refusal beats write");
      wr(8'hC0, "R3 master again");

      cyc(0, 0, 0, 8'h00, 0, 1, 0, 0, 0, 0, "R10 arbitration lost sets AL");
      idle("R5 master kept until byte end");
      cyc(0, 0, 0, 8'h00, 0, 0, 1, 0, 0, 0, "R5 byte end after AL");
      wr(8'hD0, "R7 clear");
      cyc(0, 0, 0, 8'h00, 0, 1, 1, 1, 0, 0, "R5 AL and byte end same cycle");
      wr(8'hD0, "R3 master set");

      cyc(0, 1, 0, 8'h00, 0, 0, 0, 0, 1, 0, "R10 sda high scl low with match");
      cyc(1, 1, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R10 scl high");
      cyc(1, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R10 repeated start clears flags");
      cyc(1, 1, 0, 8'h00, 0, 1, 0, 0, 0, 0, "R10 set wins over stop clear");
      cyc(0, 1, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R2 bus free");

      cyc(0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R4 prepare stop");
      cyc(1, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R4 scl high");
      cyc(1, 0, 0, 8'h00, 0, 0, 0, 0, 0, 1, "R10 general call");
      cyc(1, 1, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R2 stray stop while free");
      cyc(1, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R2 start busy");
      wr(8'hC0, "R3 master before stop");
      cyc(1, 1, 1, 8'hC0, 0, 0, 0, 0, 0, 0, "R4 R2 stop beats write");
      idle("R4 after stop");

      cyc(1, 1, 0, 8'h00, 1, 0, 0, 0, 0, 0, "R6 start granted bus free");
      idle("R6 grant lasts one cycle");
      idle("R1 final idle");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule